// File: doc/BRIEF.md
# Pipelined SPI Poller for a Four-Channel Sensor Converter

This block is the host side of a 16-bit, full-duplex SPI link to a sensor converter. The converter offers four sources (rate, temperature and two auxiliary inputs) and two output codings. A request port takes a channel number and a coding choice. For each accepted request, the block runs one frame: it lowers the chip select, sends sixteen clocks with the clock idling high, drives a command word on the data-out line and gathers the sixteen returned bits on the data-in line.

The converter answers every frame with data that was selected by the command of the frame before it. The poller therefore works as a one-deep pipeline. Each frame writes the configuration for the next conversion and reads back the result of the previous one. The returned word is paired with the request that caused it, so the first frame after reset yields nothing. Every result then leaves with a one-cycle strobe, the 12 data bits, the channel address echoed inside the returned word and an error flag. The flag is raised when the echo disagrees with the channel asked for one frame earlier, or when a leading bit is not zero.

The half period of the serial clock and the minimum chip-select high time are given in system clock cycles on two setting inputs. The block captures both when it accepts a request, so they may be changed between frames at run time.

Top module: `spi_poll_master`

## Requirements
- R1: While reset is high and in the first cycle after it, `cs_n` = 1, `sclk` = 1, `res_valid` = 0 and `req_ready` = 1.
- R2: Each frame holds `cs_n` low for exactly 16 falling edges of `sclk`, and `sclk` is high whenever `cs_n` is high.
- R3: During a frame, `mosi` carries the command word MSB first. Bit 15 = 1, bit 14 = 0, bits 13:12 = 00, bits 11:10 = requested channel, bits 9:8 = 11, bits 7:5 = 000, bit 4 = coding choice (1 offset binary, 0 twos complement), bits 3:0 = 0000. `mosi` changes only while `sclk` is high or at the chip-select fall, and it never changes at a falling edge.
- R4: `miso` is sampled at each falling edge of `sclk`, MSB first. The result `res_data` equals bits 11:0 of the returned word.
- R5: `sclk` first falls `max(half_period,1)` cycles after `cs_n` falls, and successive falling edges are `2*max(half_period,1)` cycles apart.
- R6: Between frames, `cs_n` stays high for at least `max(quiet_cycles,1)+1` cycles, using the quiet setting of the frame that just ended.
- R7: The first frame after reset produces no `res_valid`.
- R8: A result appears as a one-cycle `res_valid` in the cycle in which `cs_n` rises. Results come in request order. The result at the end of frame N belongs to the request of frame N-1, and `res_chan` holds bits 13:12 of the returned word.
- R9: `res_err` = 1 when the returned bits 13:12 differ from the channel requested in the previous frame.
- R10: `res_err` = 1 when either returned bit 15 or bit 14 is 1.
- R11: `req_ready` is high only while no frame or quiet gap is in progress. `req_valid` raised while `req_ready` is low starts no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when `req_ready` is high |
| req_chan | input | 2 | Channel to select for the next conversion |
| req_offset | input | 1 | Coding choice: 1 offset binary, 0 twos complement |
| req_ready | output | 1 | Block idle and able to start a frame |
| half_period | input | DIV_W | System cycles per `sclk` half period (0 acts as 1) |
| quiet_cycles | input | QUIET_W | Minimum chip-select high gap in cycles (0 acts as 1) |
| cs_n | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock, idles high |
| mosi | output | 1 | Command bits to the converter |
| miso | input | 1 | Returned bits from the converter |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | 12 | Returned 12-bit sample |
| res_chan | output | 2 | Channel address echoed in the returned word |
| res_err | output | 1 | Echo mismatch or non-zero leading bit |

## Verification
The properties assume that `miso` is a known level at every falling edge of `sclk`. They also assume that the converter changes `miso` only after a falling edge. The quiet-gap property compares against the setting captured at the previous request, so it assumes that `quiet_cycles` is meant to apply frame by frame. The stimulus models the converter in this way and changes `half_period` and `quiet_cycles` only while the block is idle with no frame in flight. It also raises `req_valid` during a frame, which should be refused.

// File: rtl/spi_poll_pkg.sv
package spi_poll_pkg;
  localparam int FRAME_W = 16;
  localparam int DATA_W  = 12;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_LOW, ST_HIGH, ST_HOLD, ST_QUIET
  } poll_st_e;

  // command word: write flag, fixed pattern, channel select, coding choice
  function automatic logic [FRAME_W-1:0] make_cmd(input logic [1:0] ch, input logic ofs);
    return {1'b1, 1'b0, 2'b00, ch, 2'b11, 2'b00, 1'b0, ofs, 4'b0000};
  endfunction
endpackage

// File: rtl/spi_poll_ticker.sv
module spi_poll_ticker #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic [W-1:0] limit,
  output logic         done
);
  logic [W-1:0] cnt_q;

  // limit of zero behaves as one
  assign done = ({1'b0, cnt_q} + (W+1)'(1)) >= {1'b0, limit};

  always_ff @(posedge clk) begin
    if (rst || clr) cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_poll_shift.sv
module spi_poll_shift #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_word,
  input  logic         tx_step,
  input  logic         rx_step,
  input  logic         rx_in,
  output logic         tx_out,
  output logic [W-1:0] rx_word
);
  logic [W-1:0] tx_q, rx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_q <= '0;
      rx_q <= '0;
    end else begin
      if (load)         tx_q <= load_word;
      else if (tx_step) tx_q <= {tx_q[W-2:0], 1'b0};
      if (rx_step)      rx_q <= {rx_q[W-2:0], rx_in};
    end
  end

  assign tx_out  = tx_q[W-1];
  assign rx_word = rx_q;
endmodule

// File: rtl/spi_poll_master.sv
module spi_poll_master
  import spi_poll_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int QUIET_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic [1:0]         req_chan,
  input  logic               req_offset,
  output logic               req_ready,
  input  logic [DIV_W-1:0]   half_period,
  input  logic [QUIET_W-1:0] quiet_cycles,
  output logic               cs_n,
  output logic               sclk,
  output logic               mosi,
  input  logic               miso,
  output logic               res_valid,
  output logic [DATA_W-1:0]  res_data,
  output logic [1:0]         res_chan,
  output logic               res_err
);
  localparam int CNT_W = (DIV_W > QUIET_W) ? DIV_W : QUIET_W;
  localparam int BIT_W = $clog2(FRAME_W + 1);

  poll_st_e             state_q;
  logic [DIV_W-1:0]     div_q;
  logic [QUIET_W-1:0]   quiet_q;
  logic [1:0]           cur_chan_q, prev_chan_q;
  logic                 prev_valid_q;
  logic [BIT_W-1:0]     bit_cnt_q;
  logic                 cs_n_q, sclk_q;
  logic [CNT_W-1:0]     limit;
  logic                 tick_done, tick_clr;
  logic                 accept, last_bit;
  logic                 rx_step, tx_step;
  logic [FRAME_W-1:0]   rx_word;

  assign accept   = (state_q == ST_IDLE) && req_valid;
  assign last_bit = (bit_cnt_q == BIT_W'(FRAME_W));
  assign limit    = (state_q == ST_QUIET) ? CNT_W'(quiet_q) : CNT_W'(div_q);
  assign tick_clr = (state_q == ST_IDLE) || tick_done;
  assign rx_step  = ((state_q == ST_SETUP) || (state_q == ST_HIGH)) && tick_done;
  assign tx_step  = (state_q == ST_LOW) && tick_done && !last_bit;

  spi_poll_ticker #(.W(CNT_W)) u_tick (
    .clk   (clk),
    .rst   (rst),
    .clr   (tick_clr),
    .limit (limit),
    .done  (tick_done)
  );

  spi_poll_shift #(.W(FRAME_W)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .load      (accept),
    .load_word (make_cmd(req_chan, req_offset)),
    .tx_step   (tx_step),
    .rx_step   (rx_step),
    .rx_in     (miso),
    .tx_out    (mosi),
    .rx_word   (rx_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      div_q        <= '0;
      quiet_q      <= '0;
      cur_chan_q   <= '0;
      prev_chan_q  <= '0;
      prev_valid_q <= 1'b0;
      bit_cnt_q    <= '0;
      cs_n_q       <= 1'b1;
      sclk_q       <= 1'b1;
      res_valid    <= 1'b0;
      res_data     <= '0;
      res_chan     <= '0;
      res_err      <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (req_valid) begin
          div_q      <= half_period;
          quiet_q    <= quiet_cycles;
          cur_chan_q <= req_chan;
          bit_cnt_q  <= '0;
          cs_n_q     <= 1'b0;
          state_q    <= ST_SETUP;
        end
        ST_SETUP, ST_HIGH: if (tick_done) begin
          sclk_q    <= 1'b0;
          bit_cnt_q <= bit_cnt_q + 1'b1;
          state_q   <= ST_LOW;
        end
        ST_LOW: if (tick_done) begin
          sclk_q  <= 1'b1;
          state_q <= last_bit ? ST_HOLD : ST_HIGH;
        end
        ST_HOLD: if (tick_done) begin
          cs_n_q       <= 1'b1;
          res_valid    <= prev_valid_q;
          res_data     <= rx_word[DATA_W-1:0];
          res_chan     <= rx_word[DATA_W+1:DATA_W];
          res_err      <= prev_valid_q &&
                          ((rx_word[FRAME_W-1:FRAME_W-2] != 2'b00) ||
                           (rx_word[DATA_W+1:DATA_W] != prev_chan_q));
          prev_chan_q  <= cur_chan_q;
          prev_valid_q <= 1'b1;
          state_q      <= ST_QUIET;
        end
        ST_QUIET: if (tick_done) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cs_n      = cs_n_q;
  assign sclk      = sclk_q;
  assign req_ready = (state_q == ST_IDLE);
endmodule

// File: rtl/spi_poll_chk.sv
module spi_poll_chk #(
  parameter int QUIET_W = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               cs_n,
  input logic               sclk,
  input logic               mosi,
  input logic               res_valid,
  input logic               req_ready,
  input logic [QUIET_W-1:0] quiet_q
);
  logic       sclk_d, cs_d, had_rise, seen_frame;
  logic [4:0] fall_cnt;
  logic [15:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d     <= 1'b1;
      cs_d       <= 1'b1;
      had_rise   <= 1'b0;
      seen_frame <= 1'b0;
      fall_cnt   <= '0;
      hi_cnt     <= '0;
    end else begin
      sclk_d <= sclk;
      cs_d   <= cs_n;
      if (cs_n && !cs_d) begin
        had_rise   <= 1'b1;
        seen_frame <= 1'b1;
      end
      if (cs_n)                 fall_cnt <= '0;
      else if (sclk_d && !sclk) fall_cnt <= fall_cnt + 1'b1;
      if (!cs_n)                hi_cnt <= '0;
      else if (hi_cnt != 16'hFFFF) hi_cnt <= hi_cnt + 1'b1;
    end
  end

  // R2
  idle_high_chk: assert property (@(posedge clk) disable iff (rst) cs_n |-> sclk);
  // R2
  frame_len_chk: assert property (@(posedge clk) disable iff (rst) $rose(cs_n) |-> (fall_cnt == 5'd16));
  // R3
  mosi_hold_chk: assert property (@(posedge clk) disable iff (rst) $fell(sclk) |-> $stable(mosi));
  // R6
  quiet_gap_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(cs_n) && seen_frame) |-> ((hi_cnt > 16'($past(quiet_q))) && (hi_cnt >= 16'd2)));
  // R7
  first_drop_chk: assert property (@(posedge clk) disable iff (rst) res_valid |-> had_rise);
  // R8
  res_pulse_chk: assert property (@(posedge clk) disable iff (rst) res_valid |=> !res_valid);
  // R8
  res_edge_chk: assert property (@(posedge clk) disable iff (rst) res_valid |-> $rose(cs_n));
  // R11
  ready_idle_chk: assert property (@(posedge clk) disable iff (rst) req_ready |-> (cs_n && sclk));
endmodule

bind spi_poll_master spi_poll_chk #(.QUIET_W(QUIET_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cs_n      (cs_n),
  .sclk      (sclk),
  .mosi      (mosi),
  .res_valid (res_valid),
  .req_ready (req_ready),
  .quiet_q   (quiet_q)
);

// File: tb/sim_spi_poll_master.sv
module sim_spi_poll_master;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [1:0]  req_chan = 2'd0;
  logic        req_offset = 1'b0;
  logic        req_ready;
  logic [7:0]  half_period = 8'd2;
  logic [7:0]  quiet_cycles = 8'd3;
  logic        cs_n, sclk, mosi;
  logic        miso = 1'b0;
  logic        res_valid;
  logic [11:0] res_data;
  logic [1:0]  res_chan;
  logic        res_err;

  always #10 clk = ~clk;

  spi_poll_master u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_chan(req_chan),
    .req_offset(req_offset), .req_ready(req_ready), .half_period(half_period),
    .quiet_cycles(quiet_cycles), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
    .miso(miso), .res_valid(res_valid), .res_data(res_data),
    .res_chan(res_chan), .res_err(res_err)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done_flag = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [11:0] raw_fn(input int f, input logic [1:0] ch);
    return 12'((f * 291 + int'(ch) * 1000 + 77) % 4096);
  endfunction

  function automatic int eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  typedef struct {
    logic [11:0] d;
    logic [1:0]  ch;
    logic        er;
    bit          lead;
  } exp_t;
  exp_t        expq[$];
  logic [15:0] cmdq[$];

  int inj_lead = 3;
  int inj_addr = 5;
  int req_no = 0;

  // converter model: output word reflects configuration from the previous frame
  int          frame_no = -1;
  int          sl_falls = 0;
  logic [15:0] sl_out, sl_in;
  logic [1:0]  cfg_chan = 2'd0;
  logic        cfg_code = 1'b0;

  always @(negedge cs_n) begin
    logic [11:0] raw;
    frame_no++;
    raw = raw_fn(frame_no, cfg_chan);
    sl_out = {(frame_no == inj_lead) ? 2'b01 : 2'b00,
              (frame_no == inj_addr) ? (cfg_chan ^ 2'b01) : cfg_chan,
              cfg_code ? raw : (raw ^ 12'h800)};
    sl_falls = 0;
    miso = sl_out[15];
  end

  always @(negedge sclk) begin
    if (cs_n === 1'b0) begin
      sl_in = {sl_in[14:0], mosi};
      sl_falls++;
      sl_out = {sl_out[14:0], 1'b0};
      miso = sl_out[15];
      if (sl_falls == 16) begin
        if (cmdq.size() == 0) check(1'b0, "R11 extra frame", 1, 0);
        else begin
          logic [15:0] c;
          c = cmdq.pop_front();
          check(sl_in === c, "R3 command", int'(sl_in), int'(c));
        end
        if (sl_in[15]) begin
          cfg_chan = sl_in[11:10];
          cfg_code = sl_in[4];
        end
      end
    end
  end

  always @(posedge cs_n) begin
    if (frame_no >= 0) check(sl_falls == 16, "R2 fall count", sl_falls, 16);
  end

  // timing monitor
  int cyc = 0;
  always @(posedge clk) cyc++;
  logic ps = 1'b1, pc = 1'b1;
  int   last_fall = 0, cs_fall_t = 0, cs_rise_t = 0, nfall = 0, div_cur = 1, q_prev = 1;
  bit   rose_seen = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (pc && !cs_n) begin
        if (rose_seen) check(cyc - cs_rise_t >= q_prev + 1, "R6 quiet gap", cyc - cs_rise_t, q_prev + 1);
        cs_fall_t = cyc;
        nfall = 0;
        div_cur = eff(int'(half_period));
        q_prev = eff(int'(quiet_cycles));
      end
      if (!pc && cs_n) begin
        cs_rise_t = cyc;
        rose_seen = 1;
      end
      if (ps && !sclk && !cs_n) begin
        if (nfall == 0) check(cyc - cs_fall_t == div_cur, "R5 setup", cyc - cs_fall_t, div_cur);
        else            check(cyc - last_fall == 2 * div_cur, "R5 period", cyc - last_fall, 2 * div_cur);
        last_fall = cyc;
        nfall++;
      end
      if (cs_n && !sclk) check(1'b0, "R2 idle level", 0, 1);
      if (!cs_n && req_ready) check(1'b0, "R11 ready in frame", 1, 0);
      ps = sclk;
      pc = cs_n;
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && res_valid) begin
      if (expq.size() == 0) check(1'b0, "R7 unexpected result", 1, 0);
      else begin
        exp_t e;
        e = expq.pop_front();
        check(res_data === e.d, "R4 data", int'(res_data), int'(e.d));
        check(res_chan === e.ch, "R8 channel", int'(res_chan), int'(e.ch));
        if (e.lead) check(res_err === e.er, "R10 lead error", int'(res_err), int'(e.er));
        else        check(res_err === e.er, "R9 echo error", int'(res_err), int'(e.er));
      end
    end
  end

  task automatic send(input logic [1:0] ch, input logic ofs);
    exp_t e;
    logic [11:0] raw;
    int f;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    f = req_no + 1;
    raw = raw_fn(f, ch);
    e.d = ofs ? raw : (raw ^ 12'h800);
    e.ch = (f == inj_addr) ? (ch ^ 2'b01) : ch;
    e.er = (f == inj_lead) || (f == inj_addr);
    e.lead = (f == inj_lead);
    expq.push_back(e);
    cmdq.push_back({1'b1, 1'b0, 2'b00, ch, 2'b11, 2'b00, 1'b0, ofs, 4'b0000});
    req_no++;
    req_chan = ch;
    req_offset = ofs;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!req_ready) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(cs_n === 1'b1 && sclk === 1'b1, "R1 lines in reset", int'({cs_n, sclk}), 3);
    rst = 1'b0;
    @(negedge clk);
    check(cs_n === 1'b1, "R1 cs_n", int'(cs_n), 1);
    check(sclk === 1'b1, "R1 sclk", int'(sclk), 1);
    check(res_valid === 1'b0, "R1 res_valid", int'(res_valid), 0);
    check(req_ready === 1'b1, "R1 req_ready", int'(req_ready), 1);

    send(2'd1, 1'b1); send(2'd2, 1'b0); send(2'd3, 1'b1); send(2'd0, 1'b0);
    send(2'd2, 1'b1); send(2'd1, 1'b0); send(2'd3, 1'b0);
    wait_idle();
    half_period = 8'd0;
    quiet_cycles = 8'd0;
    send(2'd0, 1'b1);
    send(2'd2, 1'b0);
    // R11: request raised during a frame must be refused
    req_chan = 2'd3; req_offset = 1'b1; req_valid = 1'b1;
    repeat (4) @(negedge clk);
    req_valid = 1'b0;
    send(2'd1, 1'b1); send(2'd3, 1'b1);
    wait_idle();
    half_period = 8'd5;
    quiet_cycles = 8'd10;
    send(2'd1, 1'b0); send(2'd0, 1'b1); send(2'd2, 1'b1);
    wait_idle();
    repeat (5) @(negedge clk);
    check(expq.size() == 1, "R8 pending results", expq.size(), 1);
    check(cmdq.size() == 0, "R3 pending commands", cmdq.size(), 0);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog R8", 0, 1);
    finish_run();
  end
endmodule